// File: doc/BRIEF.md
# Load Result Formatter

This block turns the raw bytes returned by memory for an integer load into the 64-bit value that is written to the destination register. The bytes arrive right-justified in a 64-bit word. A size code gives the access width of 1, 2, 4 or 8 bytes. Any bytes above that width are treated as don't-care.

Two mode flags select the variant of the load. The first flag sign-extends from the top bit of the access. The second flag reverses the byte order inside the access. Without sign extension, the upper bits are filled with zeros. Asking for both sign extension and byte reversal is an illegal request. The block flags it and returns zero.

The result is registered. It appears one clock after the request, together with a valid strobe. The output holds its last value between requests.

Top module: `load_fmt`

## Requirements
- R1: A 1-byte access (size code 0) places the low input byte in bits 7:0 and sets bits 63:8 to zero when sign extension is off.
- R2: A 2-byte access (size code 1) zero-fills bits 63:16, and a 4-byte access (size code 2) zero-fills bits 63:32, when both mode flags are off.
- R3: With sign extension on and byte reversal off, the result for a 1-, 2- or 4-byte access copies the top bit of the access (bit 8·n−1) into all bits above the access.
- R4: An 8-byte access (size code 3) with both flags off returns the input unchanged.
- R5: With byte reversal on, result byte i equals input byte n−1−i for i < n, where n is the access size in bytes. All bytes from n upward are zero. For a 2-byte access, the input's low byte therefore ends up in result bits 15:8.
- R6: Byte reversal on a 1-byte access gives the same result as the same access without reversal.
- R7: A request with both sign extension and byte reversal on raises out_err and returns zero data. out_err is low for every other request.
- R8: out_valid is high exactly in the cycle after a cycle with in_valid high. When in_valid is low, out_data and out_err keep their previous values.
- R9: Input bytes at position n and above, where n is the access size, do not affect the result.
- R10: While reset is high and after it is released, out_valid, out_err and out_data are zero until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | 64 | Raw memory bytes, right-justified |
| in_size | input | 2 | Access size: 0=1, 1=2, 2=4, 3=8 bytes |
| in_sext | input | 1 | Sign-extend the access |
| in_brev | input | 1 | Reverse byte order inside the access |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 64 | Formatted register value |
| out_err | output | 1 | Illegal mode combination flag |

## Verification
The properties assume that the request inputs hold known values in every cycle in which in_valid is high. They also take the size code as the access width, with no misaligned or partial data. The stimulus drives every size code with every combination of the two flags, including the illegal one. It fills the bytes above the access width with random data. It also leaves in_valid low on some cycles while the other inputs change, so that the hold behaviour is exercised.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef struct packed {
    logic sext;
    logic brev;
  } lf_mode_t;

  // Number of bytes for a size code
  function automatic int unsigned span_bytes(input int unsigned code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/lf_trim.sv
module lf_trim #(
  parameter int BYTES = 8,
  parameter int SZW   = 2,
  localparam int W    = BYTES * 8
) (
  input  logic [W-1:0]     din,
  input  logic [SZW-1:0]   size,
  output logic [BYTES-1:0] act,
  output logic [W-1:0]     dout
);
  always_comb begin
    for (int i = 0; i < BYTES; i++) begin
      act[i] = (32'(i) < lf_pkg::span_bytes(32'(size)));
    end
  end

  genvar g;
  generate
    for (g = 0; g < BYTES; g++) begin : g_byte
      assign dout[8*g +: 8] = act[g] ? din[8*g +: 8] : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/lf_bswap.sv
module lf_bswap #(
  parameter int BYTES = 8,
  parameter int SZW   = 2,
  localparam int W    = BYTES * 8,
  localparam int LOGB = $clog2(BYTES)
) (
  input  logic [W-1:0]   din,
  input  logic [SZW-1:0] size,
  input  logic           brev,
  output logic [W-1:0]   dout
);
  logic [W-1:0] sw [LOGB+1];

  genvar s, i;
  generate
    for (s = 0; s <= LOGB; s++) begin : g_size
      localparam int N = 1 << s;
      for (i = 0; i < BYTES; i++) begin : g_byte
        if (i < N) begin : g_in
          assign sw[s][8*i +: 8] = din[8*(N-1-i) +: 8];
        end else begin : g_out
          assign sw[s][8*i +: 8] = 8'h00;
        end
      end
    end
  endgenerate

  always_comb begin
    dout = din;
    if (brev) begin
      for (int k = 0; k <= LOGB; k++) begin
        if (32'(size) == 32'(k)) dout = sw[k];
      end
    end
  end
endmodule

// File: rtl/lf_sext.sv
module lf_sext #(
  parameter int BYTES = 8,
  localparam int W    = BYTES * 8
) (
  input  logic [W-1:0]     din,
  input  logic [BYTES-1:0] act,
  input  logic             sext,
  output logic [W-1:0]     dout
);
  logic sign;

  always_comb begin
    sign = 1'b0;
    for (int i = 0; i < BYTES; i++) begin
      if (act[i]) sign = din[8*i+7];
    end
  end

  genvar g;
  generate
    for (g = 0; g < BYTES; g++) begin : g_byte
      assign dout[8*g +: 8] = act[g] ? din[8*g +: 8] : {8{sext & sign}};
    end
  endgenerate
endmodule

// File: rtl/load_fmt.sv
module load_fmt #(
  parameter int BYTES = 8,
  parameter int SZW   = 2,
  localparam int W    = BYTES * 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   in_data,
  input  logic [SZW-1:0] in_size,
  input  logic           in_sext,
  input  logic           in_brev,
  output logic           out_valid,
  output logic [W-1:0]   out_data,
  output logic           out_err
);
  lf_pkg::lf_mode_t mode;
  logic [BYTES-1:0] act;
  logic [W-1:0]     trimmed, swapped, extended;
  logic             bad;

  assign mode.sext = in_sext;
  assign mode.brev = in_brev;
  assign bad       = mode.sext & mode.brev;

  lf_trim #(.BYTES(BYTES), .SZW(SZW)) u_trim (
    .din(in_data), .size(in_size), .act(act), .dout(trimmed)
  );

  lf_bswap #(.BYTES(BYTES), .SZW(SZW)) u_swap (
    .din(trimmed), .size(in_size), .brev(mode.brev), .dout(swapped)
  );

  lf_sext #(.BYTES(BYTES)) u_ext (
    .din(swapped), .act(act), .sext(mode.sext), .dout(extended)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_err  <= bad;
        out_data <= bad ? '0 : extended;
      end
    end
  end
endmodule

// File: rtl/lf_chk.sv
module lf_chk #(
  parameter int BYTES = 8,
  parameter int SZW   = 2,
  localparam int W    = BYTES * 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [W-1:0]   in_data,
  input logic [SZW-1:0] in_size,
  input logic           in_sext,
  input logic           in_brev,
  input logic           out_valid,
  input logic [W-1:0]   out_data,
  input logic           out_err
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_err))); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sext && in_brev) |=> out_err); // R7
  AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(in_sext && in_brev)) |=> !out_err); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_data == '0)); // R7
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_size == '0 && !in_sext) |=> (out_data[W-1:8] == '0)); // R1
  AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (32'd1 << in_size) == 32'(BYTES) && !in_sext && !in_brev)
      |=> (out_data == $past(in_data))); // R4
endmodule

bind load_fmt lf_chk #(.BYTES(BYTES), .SZW(SZW)) u_chk (.*);

// File: tb/load_fmt_tb.sv
module load_fmt_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_data;
  logic [1:0]  in_size;
  logic        in_sext, in_brev;
  logic        out_valid, out_err;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  load_fmt u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_size(in_size), .in_sext(in_sext), .in_brev(in_brev),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  // Expected {err, data} from the requirements
  function automatic logic [64:0] model(input logic [63:0] d, input logic [1:0] sz,
                                        input logic sx, input logic br);
    int n = 1 << sz;
    logic [63:0] r = '0;
    if (sx && br) return {1'b1, 64'h0};
    for (int i = 0; i < n; i++)
      r[8*i +: 8] = br ? d[8*(n-1-i) +: 8] : d[8*i +: 8];
    if (sx && r[8*n-1])
      for (int i = 8*n; i < 64; i++) r[i] = 1'b1;
    return {1'b0, r};
  endfunction

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a negedge, check at the next negedge
  task automatic txn(input string req, input logic [63:0] d, input logic [1:0] sz,
                     input logic sx, input logic br);
    logic [64:0] exp = model(d, sz, sx, br);
    in_valid = 1'b1; in_data = d; in_size = sz; in_sext = sx; in_brev = br;
    @(negedge clk);
    check({req, " valid"}, {64'h0, out_valid}, {64'h0, 1'b1});
    check(req, {out_err, out_data}, exp);
  endtask

  task automatic idle_check(input logic [64:0] held);
    in_valid = 1'b0; in_data = {$urandom, $urandom}; in_size = 2'($urandom);
    in_sext = 1'($urandom); in_brev = 1'($urandom);
    @(negedge clk);
    check("R8 idle valid", {64'h0, out_valid}, 65'h0);
    check("R8 hold", {out_err, out_data}, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [64:0] last;
    void'($urandom(32'd7331));
    rst = 1'b1; in_valid = 1'b0; in_data = '1; in_size = '0; in_sext = 1'b0; in_brev = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset", {63'h0, out_valid, out_err, out_data}, 65'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after release", {63'h0, out_valid, out_err, out_data}, 65'h0);

    txn("R1 R9 byte", 64'hDEAD_BEEF_1234_FF80, 2'd0, 1'b0, 1'b0);
    check("R1 value", {1'b0, out_data}, {1'b0, 64'h80});
    txn("R2 half", 64'hAAAA_AAAA_AAAA_8001, 2'd1, 1'b0, 1'b0);
    check("R2 value", {1'b0, out_data}, {1'b0, 64'h8001});
    txn("R2 word", 64'h5555_5555_F000_000F, 2'd2, 1'b0, 1'b0);
    check("R2 wvalue", {1'b0, out_data}, {1'b0, 64'hF000_000F});
    txn("R3 half neg", 64'h0000_0000_0000_8001, 2'd1, 1'b1, 1'b0);
    check("R3 value", {1'b0, out_data}, {1'b0, 64'hFFFF_FFFF_FFFF_8001});
    txn("R3 word pos", 64'hFFFF_FFFF_7FFF_FFFF, 2'd2, 1'b1, 1'b0);
    check("R3 wvalue", {1'b0, out_data}, {1'b0, 64'h0000_0000_7FFF_FFFF});
    txn("R4 dword", 64'h0123_4567_89AB_CDEF, 2'd3, 1'b0, 1'b0);
    txn("R5 half brev", 64'hFFFF_FFFF_FFFF_1234, 2'd1, 1'b0, 1'b1);
    check("R5 value", {1'b0, out_data}, {1'b0, 64'h3412});
    txn("R5 word brev", 64'h9999_9999_1122_3344, 2'd2, 1'b0, 1'b1);
    check("R5 wvalue", {1'b0, out_data}, {1'b0, 64'h4433_2211});
    txn("R5 dword brev", 64'h0102_0304_0506_0708, 2'd3, 1'b0, 1'b1);
    check("R5 dvalue", {1'b0, out_data}, {1'b0, 64'h0807_0605_0403_0201});
    txn("R6 byte brev", 64'h7777_7777_7777_77A5, 2'd0, 1'b0, 1'b1);
    check("R6 value", {1'b0, out_data}, {1'b0, 64'hA5});
    txn("R7 illegal", 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b1, 1'b1);
    check("R7 flag", {64'h0, out_err}, {64'h0, 1'b1});
    idle_check({out_err, out_data});

    for (int k = 0; k < 400; k++) begin
      logic [63:0] d = {$urandom, $urandom};
      logic [1:0]  sz = 2'($urandom);
      logic sx = 1'($urandom);
      logic br = ($urandom % 4) == 0 ? ~sx : 1'($urandom);
      txn("R1-mix R9 random", d, sz, sx, br);
      if (($urandom % 5) == 0) begin
        last = {out_err, out_data};
        idle_check(last);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule